// File: doc/BRIEF.md
# Intrusion Alarm Arming Controller

This block is the central sequencer of a small intrusion alarm. It receives a single flag telling it that the keypad code is correct, an arm request, an enter key and a vector of trip inputs from the sensors. It decides whether the installation is disarmed, counting down before arming, armed, counting down before alarming, or alarming. A valid code with an arm request starts an exit countdown so the occupant can leave. After that countdown the alarm is armed. A sensor trip while armed starts an entry countdown. If the code is not given before that countdown ends, the buzzer sounds.

Each sensor has its own indicator. An indicator latches once that sensor trips while the alarm is live, so the user can see which sensors caused the alarm. A valid code together with enter returns the block to disarmed from any state. On that return the latched indicators are cleared and a one-cycle reset pulse goes back to the code checker. Sensor inputs pass through a two-stage synchronizer before the sequencer uses them. The length of both countdowns is a parameter.

Top module: `alarm_arm_ctrl`

## Requirements
- R1: During and after reset, only `ind_disarmed` is high. `trip_led`, `buzzer` and `chk_reset` are all zero.
- R2: In the disarmed state, `code_ok` and `arm_req` high together move the block to the exit countdown on the next rising edge. `arm_req` without `code_ok` leaves it disarmed.
- R3: The exit countdown holds `ind_delay` high for exactly DELAY_CYC+1 cycles and then enters the armed state (`ind_armed` high).
- R4: Sensor trips during the exit countdown are ignored. They latch no indicator and do not start an entry countdown.
- R5: When armed, a trip on any sensor starts the entry countdown on the third rising edge after the input goes high, because of two synchronizer stages plus the state register. Bit i of `trip_led` latches for sensor `trip_in[i]`.
- R6: The entry countdown lasts exactly DELAY_CYC+1 cycles and then enters the alarm state with `buzzer` high. The buzzer stays high until the block is disarmed.
- R7: In any state other than disarmed, `code_ok` and `enter_key` high together return the block to disarmed on the next edge. That same edge clears `trip_led`. `chk_reset` is high for exactly the first disarmed cycle.
- R8: Exactly one of `ind_disarmed`, `ind_armed`, `ind_delay`, `buzzer` is high in every cycle.
- R9: While armed, in the entry countdown or alarming, `trip_led` only gains bits. A later trip on another sensor adds its bit.
- R10: `code_ok` with `enter_key` while already disarmed keeps the block disarmed and produces no `chk_reset` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_ok | input | 1 | Keypad code matches the stored code |
| arm_req | input | 1 | Arm button |
| enter_key | input | 1 | Enter key |
| trip_in | input | NSENS | Asynchronous sensor trip inputs, high = tripped |
| ind_disarmed | output | 1 | Disarmed indicator |
| ind_armed | output | 1 | Armed indicator |
| ind_delay | output | 1 | Exit or entry countdown running |
| trip_led | output | NSENS | Latched per-sensor trip indicators |
| buzzer | output | 1 | Alarm sounder enable |
| chk_reset | output | 1 | One-cycle reset pulse to the code checker |

## Verification
The bench builds the block with DELAY_CYC=3 and NSENS=3. This keeps each countdown to four cycles, so every sensor pattern can be run quickly. It sweeps all seven non-zero trip patterns through the full arm, trip, alarm and disarm sequence, and checks the latched indicators against the pattern it drove. The short countdown also makes it cheap to disarm from each of the four live states and to count countdown lengths exactly.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [2:0] {
    ST_DISARMED = 3'd0,
    ST_EXIT     = 3'd1,
    ST_ARMED    = 3'd2,
    ST_ENTRY    = 3'd3,
    ST_ALARM    = 3'd4
  } alarm_state_t;
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= 2'b00;
      else        ff_q <= {ff_q[0], d_async[i]};
    end
    assign q_sync[i] = ff_q[1];
  end
endmodule

// File: rtl/alarm_delay.sv
module alarm_delay #(
  parameter int DELAY_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic done
);
  localparam int CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign cnt_en = start | clr | run_q;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = done_q;
    if (start) begin
      cnt_d  = '0;
      run_d  = 1'b1;
      done_d = 1'b0;
    end else if (clr) begin
      cnt_d  = '0;
      run_d  = 1'b0;
      done_d = 1'b0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
  import alarm_pkg::*;
#(
  parameter int NSENS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_ok,
  input  logic             arm_req,
  input  logic             enter_key,
  input  logic [NSENS-1:0] trip_s,
  input  logic             dly_done,
  output alarm_state_t     state,
  output logic             dly_start,
  output logic             dly_clr,
  output logic [NSENS-1:0] trip_led,
  output logic             chk_reset
);
  alarm_state_t     st_q, st_d;
  logic [NSENS-1:0] led_q, led_d;
  logic             pulse_q, pulse_d;
  logic             disarm_rq;
  logic             live;

  assign disarm_rq = code_ok & enter_key;
  assign live      = (st_q == ST_ARMED) | (st_q == ST_ENTRY) | (st_q == ST_ALARM);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DISARMED: if (code_ok && arm_req) st_d = ST_EXIT;
      ST_EXIT: begin
        if (disarm_rq)     st_d = ST_DISARMED;
        else if (dly_done) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (disarm_rq)    st_d = ST_DISARMED;
        else if (|trip_s) st_d = ST_ENTRY;
      end
      ST_ENTRY: begin
        if (disarm_rq)     st_d = ST_DISARMED;
        else if (dly_done) st_d = ST_ALARM;
      end
      ST_ALARM: if (disarm_rq) st_d = ST_DISARMED;
      default: st_d = ST_DISARMED;
    endcase
  end

  always_comb begin
    dly_start = ((st_d == ST_EXIT)  && (st_q != ST_EXIT)) ||
                ((st_d == ST_ENTRY) && (st_q != ST_ENTRY));
    dly_clr   = (st_d == ST_DISARMED) || (st_d == ST_ARMED);
    pulse_d   = (st_d == ST_DISARMED) && (st_q != ST_DISARMED);
    if (st_d == ST_DISARMED) led_d = '0;
    else if (live)           led_d = led_q | trip_s;
    else                     led_d = led_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_DISARMED;
      led_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      led_q   <= led_d;
      pulse_q <= pulse_d;
    end
  end

  assign state     = st_q;
  assign trip_led  = led_q;
  assign chk_reset = pulse_q;
endmodule

// File: rtl/alarm_arm_ctrl.sv
module alarm_arm_ctrl
  import alarm_pkg::*;
#(
  parameter int NSENS     = 3,
  parameter int DELAY_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_ok,
  input  logic             arm_req,
  input  logic             enter_key,
  input  logic [NSENS-1:0] trip_in,
  output logic             ind_disarmed,
  output logic             ind_armed,
  output logic             ind_delay,
  output logic [NSENS-1:0] trip_led,
  output logic             buzzer,
  output logic             chk_reset
);
  logic             rst_n_i;
  logic [NSENS-1:0] trip_s;
  logic             dly_start, dly_clr, dly_done;
  alarm_state_t     state;

  alarm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  alarm_sync #(.W(NSENS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .d_async (trip_in),
    .q_sync  (trip_s)
  );

  alarm_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (dly_start),
    .clr   (dly_clr),
    .done  (dly_done)
  );

  alarm_fsm #(.NSENS(NSENS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .code_ok   (code_ok),
    .arm_req   (arm_req),
    .enter_key (enter_key),
    .trip_s    (trip_s),
    .dly_done  (dly_done),
    .state     (state),
    .dly_start (dly_start),
    .dly_clr   (dly_clr),
    .trip_led  (trip_led),
    .chk_reset (chk_reset)
  );

  assign ind_disarmed = (state == ST_DISARMED);
  assign ind_armed    = (state == ST_ARMED);
  assign ind_delay    = (state == ST_EXIT) || (state == ST_ENTRY);
  assign buzzer       = (state == ST_ALARM);
endmodule

// File: rtl/alarm_arm_ctrl_chk.sv
module alarm_arm_ctrl_chk #(
  parameter int NSENS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             code_ok,
  input logic             enter_key,
  input logic             ind_disarmed,
  input logic             ind_armed,
  input logic             ind_delay,
  input logic [NSENS-1:0] trip_led,
  input logic             buzzer,
  input logic             chk_reset
);
  // R8
  one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ind_disarmed, ind_armed, ind_delay, buzzer}) == 1);

  // R7
  disarm_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_ok && enter_key && !ind_disarmed) |=> (ind_disarmed && chk_reset));

  // R7
  pulse_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_reset |-> ind_disarmed);

  // R7
  led_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind_disarmed |-> (trip_led == '0));

  // R3
  arm_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ind_armed) |-> $past(ind_delay));

  // R6
  buzz_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buzzer) |-> $past(ind_delay));

  // R6
  buzz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buzzer && !(code_ok && enter_key)) |=> buzzer);

  // R9
  led_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_disarmed && !(code_ok && enter_key)) |=>
      ((trip_led & $past(trip_led)) == $past(trip_led)));
endmodule

bind alarm_arm_ctrl alarm_arm_ctrl_chk #(.NSENS(NSENS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .code_ok      (code_ok),
  .enter_key    (enter_key),
  .ind_disarmed (ind_disarmed),
  .ind_armed    (ind_armed),
  .ind_delay    (ind_delay),
  .trip_led     (trip_led),
  .buzzer       (buzzer),
  .chk_reset    (chk_reset)
);

// File: tb/alarm_arm_ctrl_test.sv
module alarm_arm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSENS      = 3;
  localparam int DLY        = 3;
  localparam int WDOG       = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             code_ok, arm_req, enter_key;
  logic [NSENS-1:0] trip_in;
  logic             ind_disarmed, ind_armed, ind_delay, buzzer, chk_reset;
  logic [NSENS-1:0] trip_led;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_arm_ctrl #(.NSENS(NSENS), .DELAY_CYC(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .code_ok(code_ok), .arm_req(arm_req),
    .enter_key(enter_key), .trip_in(trip_in), .ind_disarmed(ind_disarmed),
    .ind_armed(ind_armed), .ind_delay(ind_delay), .trip_led(trip_led),
    .buzzer(buzzer), .chk_reset(chk_reset)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st_code();
    return {28'd0, buzzer, ind_delay, ind_armed, ind_disarmed};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    code_ok = 0; arm_req = 0; enter_key = 0; trip_in = '0;
  endtask

  task automatic do_arm();
    code_ok = 1; arm_req = 1;
    step();
    code_ok = 0; arm_req = 0;
  endtask

  task automatic do_disarm();
    code_ok = 1; enter_key = 1;
    step();
    code_ok = 0; enter_key = 0;
  endtask

  task automatic count_delay(output int n);
    n = 0;
    while (ind_delay) begin
      n++;
      step();
    end
  endtask

  task automatic trip(input logic [NSENS-1:0] p);
    trip_in = p;
    step();
    trip_in = '0;
    step();
    step();
  endtask

  task automatic arm_fully();
    int n;
    do_arm();
    count_delay(n);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=0", WDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", st_code(), 1);
    check("R1 leds", int'(trip_led), 0);
    check("R1 chk_reset", int'(chk_reset), 0);
    rst_n = 1;
    repeat (4) step();
    check("R1 after release", st_code(), 1);

    // R2 arm without code ignored
    arm_req = 1; step(); arm_req = 0;
    check("R2 no code", st_code(), 1);
    // R10 disarm while disarmed
    do_disarm();
    check("R10 state", st_code(), 1);
    check("R10 chk_reset", int'(chk_reset), 0);

    // sweep every trip pattern
    for (int p = 1; p < (1 << NSENS); p++) begin
      do_arm();
      check("R2 exit entered", st_code(), 4);
      // R4 trip during exit countdown ignored
      if (p == 1) begin
        trip_in = '1; step(); trip_in = '0;
        check("R4 leds", int'(trip_led), 0);
      end
      count_delay(n);
      check("R3 exit length", n + ((p == 1) ? 1 : 0), DLY + 1);
      check("R3 armed", st_code(), 2);
      if (p == 1) check("R4 leds after", int'(trip_led), 0);
      trip(NSENS'(p));
      check("R5 entry", st_code(), 4);
      check("R5 leds", int'(trip_led), p);
      count_delay(n);
      check("R6 entry length", n, DLY + 1);
      check("R6 buzzer", st_code(), 8);
      repeat (5) step();
      check("R6 buzzer hold", int'(buzzer), 1);
      do_disarm();
      check("R7 state", st_code(), 1);
      check("R7 pulse", int'(chk_reset), 1);
      check("R7 leds clear", int'(trip_led), 0);
      step();
      check("R7 pulse width", int'(chk_reset), 0);
    end

    // R9 accumulation: sensor 0 then sensor 2 during entry
    arm_fully();
    trip(3'b001);
    trip(3'b100);
    check("R9 accumulate", int'(trip_led), 5);
    do_disarm();

    // R7 disarm from exit, armed, entry
    do_arm();
    step();
    do_disarm();
    check("R7 from exit", st_code(), 1);
    check("R7 pulse exit", int'(chk_reset), 1);
    arm_fully();
    do_disarm();
    check("R7 from armed", st_code(), 1);
    arm_fully();
    trip(3'b010);
    step();
    do_disarm();
    check("R7 from entry", st_code(), 1);
    check("R7 leds entry", int'(trip_led), 0);
    step();
    check("R7 stays", st_code(), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule